// File: doc/BRIEF.md
# Streaming Minimum Selector with Winner Index

This block chooses the cheapest of a fixed number of candidates that arrive one after another. Each candidate is an unsigned 8-bit cost on a valid/ready input stream. The block keeps the smallest cost seen so far in the current group, together with the position of that cost within the group. When the last candidate of the group is accepted, the block registers the winning cost and its 4-bit position. In the following cycle it raises a one-cycle `done` flag. A mode-decision stage can use this to select the cheapest of four coding modes, for example.

The input follows valid/ready rules. A sample moves on a clock edge where `in_valid` and `in_ready` are both high. The block never stalls on its own: `in_ready` is low only while the synchronous `init` input is high. A sample offered during an `init` cycle is not taken, and the source must hold it or offer it again. `init` clears the running minimum and the group position, so a new group can be started at any point. A new group may begin directly after the last candidate of the previous one, with no idle cycle in between.

Top module: `minsel_stream`

## Requirements
- R1: While `rst` (asynchronous, active high) is asserted and after its release, `done` is 0, `win_cost` is 0xFF, `win_index` is 0, and `in_ready` is 1 whenever `init` is low.
- R2: Costs are compared as unsigned magnitudes, so 0x7F beats 0x80 and 0x00 beats every other value.
- R3: A later candidate replaces the running minimum only when it is strictly smaller, so on equal costs the earliest position wins.
- R4: `done` is high for exactly one cycle, the cycle after the fourth accepted candidate of a group. In that cycle `win_cost` and `win_index` carry that group's result.
- R5: Only cycles with `in_valid` and `in_ready` both high count as candidates. Idle cycles between candidates change neither the group position nor the result.
- R6: While `init` is high, `in_ready` is 0 and any offered sample is dropped. The running minimum is reseeded to 0xFF and the group position returns to 0, even in a cycle that would otherwise have been the last candidate.
- R7: `win_cost` and `win_index` keep their values in every cycle except the one in which `done` is high, including through `init` and idle cycles.
- R8: The first candidate of each group loads without comparison, so a group that follows directly after a group containing 0x00 still reports its own minimum.
- R9: `win_index` is the 0-based position (0 to 3) of the winning candidate in acceptance order, zero-extended to 4 bits.
- R10: A group whose candidates are all 0xFF reports cost 0xFF at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| init | input | 1 | Synchronous group restart; blocks input while high |
| in_valid | input | 1 | Candidate cost present on `in_cost` |
| in_ready | output | 1 | Block can accept a candidate this cycle |
| in_cost | input | 8 | Unsigned candidate cost |
| done | output | 1 | One-cycle pulse: group result is on the outputs |
| win_cost | output | 8 | Smallest cost of the last completed group |
| win_index | output | 4 | Position of that cost within its group |

## Verification
An exhaustive sweep runs every ordered group built from the costs 0x00, 0x01, 0x7F, 0x80 and 0xFF, with groups sent back to back. This separates magnitude comparison from bit-pattern comparison, tells strict replacement apart from replacement on ties at every position, and covers the unconditional load of each group's first candidate. Directed sequences then add idle gaps between candidates to show that only accepted cycles count. Further sequences raise `init` in the middle of a group and on what would have been the last candidate, to show that the offered sample is dropped and the count restarts. Other sequences confirm that the result registers hold across these events.

// File: rtl/minsel_pkg.sv
package minsel_pkg;

  localparam int MINSEL_COST_W = 8;
  localparam int MINSEL_POS_W  = 4;
  localparam int MINSEL_GROUP  = 4;

  typedef logic [MINSEL_COST_W-1:0] cost_t;
  typedef logic [MINSEL_POS_W-1:0]  pos_t;

  typedef struct packed {
    cost_t cost;
    pos_t  pos;
  } cand_t;

  localparam cost_t COST_SEED = '1;

  function automatic cand_t seed_cand();
    cand_t c;
    c.cost = COST_SEED;
    c.pos  = '0;
    return c;
  endfunction

endpackage

// File: rtl/minsel_slot_ctr.sv
module minsel_slot_ctr
  import minsel_pkg::*;
#(
  parameter int GROUP_N = MINSEL_GROUP
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output pos_t pos,
  output logic is_first,
  output logic is_last
);

  localparam pos_t LAST_POS = pos_t'(GROUP_N - 1);

  pos_t pos_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
    end else if (step) begin
      if (pos_q == LAST_POS) pos_q <= '0;
      else                   pos_q <= pos_q + pos_t'(1);
    end
  end

  assign pos      = pos_q;
  assign is_first = (pos_q == '0);
  assign is_last  = (pos_q == LAST_POS);

  // R6: a clear always returns the position to zero
  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pos == '0));

  // R5: cycles without an accepted candidate leave the position alone
  a_r5_idle_holds_pos: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(pos));

endmodule

// File: rtl/minsel_pick.sv
module minsel_pick
  import minsel_pkg::*;
(
  input  cand_t cur,
  input  cost_t new_cost,
  input  pos_t  new_pos,
  input  logic  first,
  output cand_t nxt,
  output logic  take
);

  logic smaller;

  always_comb begin
    smaller = (new_cost < cur.cost);
    take    = first || smaller;
    if (take) begin
      nxt.cost = new_cost;
      nxt.pos  = new_pos;
    end else begin
      nxt = cur;
    end
  end

endmodule

// File: rtl/minsel_result.sv
module minsel_result
  import minsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  capture,
  input  cand_t cand_in,
  output logic  done,
  output cand_t win
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      done <= 1'b0;
      win  <= seed_cand();
    end else begin
      done <= capture;
      if (capture) win <= cand_in;
    end
  end

  // R4: the completion pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: completion follows a capture request by one cycle
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(capture));

  // R7: the result holds outside completion cycles
  a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(win));

endmodule

// File: rtl/minsel_stream.sv
module minsel_stream
  import minsel_pkg::*;
#(
  parameter int GROUP_N = MINSEL_GROUP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [MINSEL_COST_W-1:0] in_cost,
  output logic                     done,
  output logic [MINSEL_COST_W-1:0] win_cost,
  output logic [MINSEL_POS_W-1:0]  win_index
);

  logic  accept;
  pos_t  pos;
  logic  is_first;
  logic  is_last;
  cand_t run_q;
  cand_t run_nxt;
  logic  take;
  cand_t win;

  assign in_ready = !init;
  assign accept   = in_valid && in_ready;

  minsel_slot_ctr #(.GROUP_N(GROUP_N)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clear    (init),
    .step     (accept),
    .pos      (pos),
    .is_first (is_first),
    .is_last  (is_last)
  );

  minsel_pick u_pick (
    .cur      (run_q),
    .new_cost (in_cost),
    .new_pos  (pos),
    .first    (is_first),
    .nxt      (run_nxt),
    .take     (take)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run_q <= seed_cand();
    end else if (init) begin
      run_q <= seed_cand();
    end else if (accept) begin
      run_q <= run_nxt;
    end
  end

  minsel_result u_res (
    .clk     (clk),
    .rst     (rst),
    .capture (accept && is_last),
    .cand_in (run_nxt),
    .done    (done),
    .win     (win)
  );

  assign win_cost  = win.cost;
  assign win_index = win.pos;

  // R3: a later candidate that is not strictly smaller leaves the minimum unchanged
  a_r3_keep_on_tie: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_first && (in_cost >= run_q.cost)) |=> $stable(run_q));

  // R6: init reseeds the running minimum to all ones
  a_r6_init_reseeds: assert property (@(posedge clk) disable iff (rst)
    init |=> (run_q.cost == COST_SEED));

  // R9: the reported position stays inside the group
  a_r9_index_in_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(win_index) < GROUP_N));

endmodule

// File: tb/sim_minsel_stream.sv
module sim_minsel_stream;

  logic       clk = 1'b0;
  logic       rst;
  logic       init;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_cost;
  logic       done;
  logic [7:0] win_cost;
  logic [3:0] win_index;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  minsel_stream u0 (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cost   (in_cost),
    .done      (done),
    .win_cost  (win_cost),
    .win_index (win_index)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] c, input logic i);
    in_valid = v;
    in_cost  = c;
    init     = i;
  endtask

  task automatic check_result(input string tag, input int c, input int ix);
    check({tag, " done"}, int'(done), 1);
    check({tag, " cost"}, int'(win_cost), c);
    check({tag, " index"}, int'(win_index), ix);
  endtask

  task automatic check_quiet(input string tag, input int c, input int ix);
    check({tag, " done low"}, int'(done), 0);
    check({tag, " cost held"}, int'(win_cost), c);
    check({tag, " index held"}, int'(win_index), ix);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] vals [5];
    logic [7:0] t [4];
    int pmn;
    int pix;
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7F; vals[3] = 8'h80; vals[4] = 8'hFF;
    pmn = 0;
    pix = 0;

    rst = 1'b1;
    drive(1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset cost", int'(win_cost), 8'hFF);
    check("R1 reset index", int'(win_index), 0);
    check("R1 reset ready", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after release", 8'hFF, 0);

    // R2 R3 R8 R10: exhaustive back-to-back sweep over 5 costs per position
    for (int g = 0; g < 625; g++) begin
      int mn;
      int ix;
      int d;
      d = g;
      for (int k = 0; k < 4; k++) begin
        t[k] = vals[d % 5];
        d = d / 5;
      end
      mn = 256;
      ix = 0;
      for (int k = 0; k < 4; k++) begin
        if (int'(t[k]) < mn) begin
          mn = int'(t[k]);
          ix = k;
        end
      end
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (k == 0 && g > 0) check_result("R2/R3/R8 sweep", pmn, pix);
        else check("R4 no early done", int'(done), 0);
        drive(1'b1, t[k], 1'b0);
      end
      pmn = mn;
      pix = ix;
    end
    @(negedge clk);
    check_result("R10 sweep last (all 0xFF)", pmn, pix);
    drive(1'b0, 8'h00, 1'b0);
    @(negedge clk);
    check_quiet("R4 pulse ends / R7 hold", pmn, pix);

    // R2 directed: 0x80 must lose to 0x7F
    for (int k = 0; k < 4; k++) begin
      logic [7:0] g2 [4];
      g2[0] = 8'h80; g2[1] = 8'h7F; g2[2] = 8'hFF; g2[3] = 8'h81;
      @(negedge clk);
      drive(1'b1, g2[k], 1'b0);
    end
    @(negedge clk);
    check_result("R2 magnitude", 8'h7F, 1);
    drive(1'b0, 8'h00, 1'b0);

    // R3 R9 directed: tie at positions 1 and 2 keeps position 1
    for (int k = 0; k < 4; k++) begin
      logic [7:0] g3 [4];
      g3[0] = 8'h33; g3[1] = 8'h22; g3[2] = 8'h22; g3[3] = 8'h40;
      @(negedge clk);
      drive(1'b1, g3[k], 1'b0);
    end
    @(negedge clk);
    check_result("R3 tie keeps earlier", 8'h22, 1);
    drive(1'b0, 8'h00, 1'b0);

    // R8 directed: group with 0x00, then directly a group without it
    for (int k = 0; k < 8; k++) begin
      logic [7:0] g8 [8];
      g8[0] = 8'h05; g8[1] = 8'h00; g8[2] = 8'h09; g8[3] = 8'h07;
      g8[4] = 8'hC0; g8[5] = 8'h90; g8[6] = 8'hA0; g8[7] = 8'hB0;
      @(negedge clk);
      if (k == 4) check_result("R8 first group", 8'h00, 1);
      drive(1'b1, g8[k], 1'b0);
    end
    @(negedge clk);
    check_result("R8 second group own minimum", 8'h90, 1);
    drive(1'b0, 8'h00, 1'b0);

    // R5: idle gaps between candidates
    @(negedge clk); drive(1'b1, 8'h60, 1'b0);
    @(negedge clk); drive(1'b0, 8'h01, 1'b0);
    @(negedge clk); check_quiet("R5 gap", 8'h90, 1); drive(1'b0, 8'h00, 1'b0);
    @(negedge clk); drive(1'b1, 8'h20, 1'b0);
    @(negedge clk); drive(1'b0, 8'h02, 1'b0);
    @(negedge clk); check_quiet("R5 gap", 8'h90, 1); drive(1'b1, 8'h90, 1'b0);
    @(negedge clk); drive(1'b0, 8'h00, 1'b0);
    @(negedge clk); check_quiet("R5 gap before last", 8'h90, 1); drive(1'b1, 8'h25, 1'b0);
    @(negedge clk);
    check_result("R5 gapped group", 8'h20, 1);
    drive(1'b0, 8'h00, 1'b0);

    // R6: init mid-group drops offered sample and restarts count
    @(negedge clk); drive(1'b1, 8'h10, 1'b0);
    @(negedge clk); drive(1'b1, 8'h05, 1'b0);
    @(negedge clk); drive(1'b1, 8'h00, 1'b1);
    #1 check("R6 ready low during init", int'(in_ready), 0);
    @(negedge clk);
    check_quiet("R7 hold through init", 8'h20, 1);
    drive(1'b1, 8'h50, 1'b0);
    @(negedge clk); check("R6 restart count", int'(done), 0); drive(1'b1, 8'h40, 1'b0);
    @(negedge clk); check("R6 restart count", int'(done), 0); drive(1'b1, 8'h60, 1'b0);
    @(negedge clk); check("R6 restart count", int'(done), 0); drive(1'b1, 8'h70, 1'b0);
    @(negedge clk);
    check_result("R6 group after init", 8'h40, 1);
    drive(1'b0, 8'h00, 1'b0);

    // R6: init on would-be last candidate cancels completion
    @(negedge clk); drive(1'b1, 8'h11, 1'b0);
    @(negedge clk); drive(1'b1, 8'h22, 1'b0);
    @(negedge clk); drive(1'b1, 8'h33, 1'b0);
    @(negedge clk); drive(1'b1, 8'h01, 1'b1);
    @(negedge clk);
    check_quiet("R6 init cancels last / R7", 8'h40, 1);
    drive(1'b0, 8'h00, 1'b0);
    @(negedge clk);
    check_quiet("R6 no late done", 8'h40, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] g6 [4];
      g6[0] = 8'h44; g6[1] = 8'h55; g6[2] = 8'h66; g6[3] = 8'h77;
      @(negedge clk);
      drive(1'b1, g6[k], 1'b0);
    end
    @(negedge clk);
    check_result("R6 R9 fresh group index 0", 8'h44, 0);
    drive(1'b0, 8'h00, 1'b0);
    @(negedge clk);
    check_quiet("R4 R7 final hold", 8'h44, 0);

    summary();
  end

endmodule